// File: doc/BRIEF.md
# Oversampling UART receiver with majority voting

This block recovers characters from an asynchronous serial line. The line is first passed through a two-flop synchronizer. It is then sampled only on cycles where an external oversampling tick enable is high. In normal speed each bit lasts 16 ticks. In double speed each bit lasts 8 ticks. Every bit of a frame is resolved by a two-of-three vote over three consecutive samples near the bit centre. This covers the start bit, the data bits, the optional parity bit and the stop bit.

A frame begins with a high-to-low transition on the sampled line. The start bit must vote low, otherwise the event is treated as a glitch and dropped. The data bits arrive least significant bit first. The data width ranges from 5 to 9 bits, and an optional even or odd parity bit may follow, so data plus parity spans 5 to 10 bits. Once the last vote sample of the stop bit is taken, the character, a frame-error flag and a parity-error flag are presented together with a one-cycle valid pulse. The receiver then goes straight back to hunting for the next start edge, without waiting for the tail of the stop bit. Baud-rate generation, buffering and any transmit path belong to neighbouring blocks.

Top module: `uart_os_rx`

## Requirements
- R1: The serial input reaches the bit logic only through a two-flop synchronizer whose flops reset to 1. A sample taken on a tick is the line value from two clock cycles earlier.
- R2: With dblSpeed=0 a bit spans 16 ticks. The tick that first sees the low start level is sample 1, and samples 8, 9 and 10 of each bit are the vote samples.
- R3: With dblSpeed=1 a bit spans 8 ticks, counted the same way, and samples 4, 5 and 6 are the vote samples.
- R4: A bit resolves to 1 when at least two of its three vote samples are 1. A single disagreeing vote sample does not change the result, and two disagreeing samples do.
- R5: A start is recognised only on a tick whose sample is 0 while the previous tick's sample was 1. If the start bit then votes 1, no character is produced and the receiver hunts again.
- R6: dataBits (5..9) data bits are received least significant bit first. They are reported right-justified in rxData, and the rxData bits at positions dataBits and above read 0.
- R7: With parityEn=1 one parity bit follows the data. parityOdd=0 selects even parity, where the data bits plus the parity bit hold an even count of ones. parityOdd=1 selects odd parity. parityErr is 1 on a mismatch, and the character is still delivered.
- R8: The stop bit is voted like any other bit. frameErr is 1 when it resolves to 0, and the character is still delivered.
- R9: rxValid is high for exactly one cycle: the clock after the tick that takes the stop bit's last vote sample. rxData, frameErr and parityErr change only with rxValid and are held until the next character.
- R10: A start edge on the tick right after the stop bit's last vote sample begins a new frame. Both characters are received.
- R11: Cycles without sampleTick change no receiver state, whatever the line does.
- R12: With parityEn=0 no parity bit is expected, and parityErr stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Asynchronous serial line, idle high |
| sampleTick | input | 1 | Oversampling tick enable, one sample per high cycle |
| dblSpeed | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| dataBits | input | 4 | Number of data bits, 5 to 9 |
| parityEn | input | 1 | 1: a parity bit follows the data |
| parityOdd | input | 1 | 0: even parity, 1: odd parity |
| rxData | output | 9 | Received character, right-justified |
| rxValid | output | 1 | One-cycle strobe marking a new character |
| frameErr | output | 1 | Stop bit voted 0 for the current character |
| parityErr | output | 1 | Parity mismatch for the current character |

## Verification
Two functions can fall in the same clock cycle. One is the registered delivery of a finished character. The other is start-edge detection for the next frame, which happens when the next frame's start bit follows a stop bit cut off right after its last vote sample. The bench provokes this with continuous ticks and a shortened stop bit. In that setting the valid pulse and the new start sample land on the same clock. A behavioural reference model, compared every clock, must see both the first character and a correctly decoded second one.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic clearFrame;  // start edge seen: wipe frame accumulators
    logic takeFirst;   // capture first vote sample
    logic takeMid;     // capture middle vote sample
    logic shiftData;   // voted data bit available
    logic takeParity;  // voted parity bit available
    logic finish;      // voted stop bit available: publish character
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_ctrl.sv
module uart_os_rx_ctrl
  import uart_os_rx_pkg::*;
#(
  parameter int MAX_DATA = 9,
  parameter int NORM_OSR = 16,
  parameter int DBL_OSR  = 8,
  localparam int BIT_W   = $clog2(MAX_DATA + 1),
  localparam int CNT_W   = $clog2(NORM_OSR + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxS,
  input  logic             dblSpeed,
  input  logic [BIT_W-1:0] dataBits,
  input  logic             parityEn,
  input  logic             voteBit,
  output rxStrobe_t        strobe
);
  localparam int NORM_FIRST = NORM_OSR / 2;
  localparam int DBL_FIRST  = DBL_OSR / 2;

  rxState_t         state;
  logic [CNT_W-1:0] sIdx;      // index of the sample taken on this tick
  logic [BIT_W-1:0] bitCnt;
  logic             lastS;     // sample value of the previous tick
  logic [CNT_W-1:0] firstV, midV, lastV, endV;
  logic             inFrame, lastHit;

  always_comb begin
    firstV  = dblSpeed ? CNT_W'(DBL_FIRST)     : CNT_W'(NORM_FIRST);
    midV    = dblSpeed ? CNT_W'(DBL_FIRST + 1) : CNT_W'(NORM_FIRST + 1);
    lastV   = dblSpeed ? CNT_W'(DBL_FIRST + 2) : CNT_W'(NORM_FIRST + 2);
    endV    = dblSpeed ? CNT_W'(DBL_OSR)       : CNT_W'(NORM_OSR);
    inFrame = (state != ST_HUNT);
    lastHit = inFrame && sampleTick && (sIdx == lastV);

    strobe            = '0;
    strobe.clearFrame = (state == ST_HUNT) && sampleTick && lastS && !rxS;
    strobe.takeFirst  = inFrame && sampleTick && (sIdx == firstV);
    strobe.takeMid    = inFrame && sampleTick && (sIdx == midV);
    strobe.shiftData  = lastHit && (state == ST_DATA);
    strobe.takeParity = lastHit && (state == ST_PAR);
    strobe.finish     = lastHit && (state == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      sIdx   <= CNT_W'(1);
      bitCnt <= '0;
      lastS  <= 1'b1;
    end else if (sampleTick) begin
      lastS <= rxS;
      if (state == ST_HUNT) begin
        if (strobe.clearFrame) begin
          state  <= ST_START;
          sIdx   <= CNT_W'(2);
          bitCnt <= '0;
        end
      end else begin
        if (lastHit && ((state == ST_START && voteBit) || state == ST_STOP)) begin
          // glitch rejected, or stop resolved: hunt at once
          state <= ST_HUNT;
          sIdx  <= CNT_W'(1);
        end else if (sIdx == endV) begin
          sIdx <= CNT_W'(1);
          case (state)
            ST_START: state <= ST_DATA;
            ST_DATA:  if (bitCnt == dataBits) state <= parityEn ? ST_PAR : ST_STOP;
            ST_PAR:   state <= ST_STOP;
            default:  state <= state;
          endcase
        end else begin
          sIdx <= sIdx + CNT_W'(1);
        end
        if (strobe.shiftData) bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_dp.sv
module uart_os_rx_dp
  import uart_os_rx_pkg::*;
#(
  parameter int MAX_DATA = 9,
  localparam int BIT_W   = $clog2(MAX_DATA + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxS,
  input  rxStrobe_t           strobe,
  input  logic [BIT_W-1:0]    dataBits,
  input  logic                parityEn,
  input  logic                parityOdd,
  output logic                voteBit,
  output logic [MAX_DATA-1:0] rxData,
  output logic                rxValid,
  output logic                frameErr,
  output logic                parityErr
);
  logic                v0, v1;
  logic [MAX_DATA-1:0] shiftReg;
  logic                runXor, parBit;
  logic [BIT_W-1:0]    dropCnt;

  assign voteBit = maj3(v0, v1, rxS);
  assign dropCnt = BIT_W'(MAX_DATA) - dataBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v0        <= 1'b1;
      v1        <= 1'b1;
      shiftReg  <= '0;
      runXor    <= 1'b0;
      parBit    <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      rxValid <= strobe.finish;
      if (strobe.takeFirst) v0 <= rxS;
      if (strobe.takeMid)   v1 <= rxS;
      if (strobe.clearFrame) begin
        shiftReg <= '0;
        runXor   <= 1'b0;
        parBit   <= 1'b0;
      end
      if (strobe.shiftData) begin
        shiftReg <= {voteBit, shiftReg[MAX_DATA-1:1]};
        runXor   <= runXor ^ voteBit;
      end
      if (strobe.takeParity) parBit <= voteBit;
      if (strobe.finish) begin
        rxData    <= shiftReg >> dropCnt;
        frameErr  <= ~voteBit;
        parityErr <= parityEn && (parBit != (runXor ^ parityOdd));
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int MAX_DATA    = 9,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W      = $clog2(MAX_DATA + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  logic                sampleTick,
  input  logic                dblSpeed,
  input  logic [BIT_W-1:0]    dataBits,
  input  logic                parityEn,
  input  logic                parityOdd,
  output logic [MAX_DATA-1:0] rxData,
  output logic                rxValid,
  output logic                frameErr,
  output logic                parityErr
);
  logic      rxS;
  logic      voteBit;
  rxStrobe_t strobe;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .din(rxIn), .dout(rxS)
  );

  uart_os_rx_ctrl #(.MAX_DATA(MAX_DATA)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxS(rxS),
    .dblSpeed(dblSpeed), .dataBits(dataBits), .parityEn(parityEn),
    .voteBit(voteBit), .strobe(strobe)
  );

  uart_os_rx_dp #(.MAX_DATA(MAX_DATA)) i_dp (
    .clk(clk), .rstN(rstN), .rxS(rxS), .strobe(strobe),
    .dataBits(dataBits), .parityEn(parityEn), .parityOdd(parityOdd),
    .voteBit(voteBit), .rxData(rxData), .rxValid(rxValid),
    .frameErr(frameErr), .parityErr(parityErr)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int MAX_DATA = 9,
  localparam int BIT_W   = $clog2(MAX_DATA + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleTick,
  input logic [BIT_W-1:0]    dataBits,
  input logic                parityEn,
  input logic [MAX_DATA-1:0] rxData,
  input logic                rxValid,
  input logic                frameErr,
  input logic                parityErr
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R11
  tick_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(sampleTick));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxData) && $stable(frameErr) && $stable(parityErr)));

  // R12
  no_parity_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityEn) |-> !parityErr);

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> dataBits) == '0));
endmodule

bind uart_os_rx uart_os_rx_chk #(.MAX_DATA(MAX_DATA)) i_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .dataBits(dataBits),
  .parityEn(parityEn), .rxData(rxData), .rxValid(rxValid),
  .frameErr(frameErr), .parityErr(parityErr)
);

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       line = 1'b1;
  logic       tick = 1'b0;
  logic       cfgDbl = 1'b0;
  logic [3:0] cfgBits = 4'd8;
  logic       cfgPar = 1'b0;
  logic       cfgOdd = 1'b0;
  logic [8:0] rxData;
  logic       rxValid, frameErr, parityErr;

  int checks = 0, failures = 0, gap = 2;
  int gotData[$];
  int gotFe[$];
  int gotPe[$];

  always #5 clk = ~clk;

  uart_os_rx i_uart_os_rx (
    .clk(clk), .rstN(rstN), .rxIn(line), .sampleTick(tick), .dblSpeed(cfgDbl),
    .dataBits(cfgBits), .parityEn(cfgPar), .parityOdd(cfgOdd),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr), .parityErr(parityErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m1 = 1, m2 = 1, mLast = 1, hunt = 1;
  bit smp[$];
  bit mValid = 0, mFe = 0, mPe = 0, parV = 0;
  int mData = 0, acc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      m1 = 1; m2 = 1; mLast = 1; hunt = 1; mValid = 0;
      mData = 0; mFe = 0; mPe = 0; smp.delete();
    end else begin
      bit cur;
      cur = m2; m2 = m1; m1 = line;
      mValid = 0;
      if (tick) begin
        if (hunt) begin
          if (mLast && !cur) begin
            hunt = 0; smp.delete(); smp.push_back(cur); acc = 0; parV = 0;
          end
        end else begin
          int n, spb, lv, pos, bitNo;
          bit v;
          spb = cfgDbl ? 8 : 16;
          lv = cfgDbl ? 6 : 10;
          smp.push_back(cur);
          n = smp.size();
          pos = (n - 1) % spb + 1;
          bitNo = (n - 1) / spb;
          if (pos == lv) begin
            v = (int'(smp[n-1]) + int'(smp[n-2]) + int'(smp[n-3])) >= 2;
            if (bitNo == 0) begin
              if (v) hunt = 1;
            end else if (bitNo <= int'(cfgBits)) begin
              if (v) acc = acc | (1 << (bitNo - 1));
            end else if (cfgPar && bitNo == int'(cfgBits) + 1) begin
              parV = v;
            end else begin
              mValid = 1; mData = acc; mFe = !v;
              mPe = cfgPar && (parV != ((^acc[8:0]) ^ cfgOdd));
              hunt = 1;
            end
          end
        end
        mLast = cur;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(rxValid === mValid, "R9 R1 rxValid vs model", int'(rxValid), int'(mValid));
      if (mValid) begin
        chk(int'(rxData) == mData, "R6 rxData vs model", int'(rxData), mData);
        chk(frameErr === mFe, "R8 frameErr vs model", int'(frameErr), int'(mFe));
        chk(parityErr === mPe, "R7 parityErr vs model", int'(parityErr), int'(mPe));
      end
      if (rxValid) begin
        gotData.push_back(int'(rxData));
        gotFe.push_back(int'(frameErr));
        gotPe.push_back(int'(parityErr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic oneTick(input bit v);
    @(negedge clk);
    line = v; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) oneTick(1'b1);
  endtask

  // pmode: 0 none, 1 even, 2 odd; flips are 0-based sample indices, -1 = none
  task automatic sendFrame(input int data, input int nb, input int pmode, input bit badPar,
                           input bit stopVal, input int stopLen, input int flipA, input int flipB);
    bit q[$];
    int spb;
    bit pb;
    spb = cfgDbl ? 8 : 16;
    for (int i = 0; i < spb; i++) q.push_back(1'b0);
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < spb; i++) q.push_back(bit'((data >> b) & 1));
    if (pmode != 0) begin
      pb = 1'b0;
      for (int b = 0; b < nb; b++) pb ^= bit'((data >> b) & 1);
      if (pmode == 2) pb = ~pb;
      if (badPar) pb = ~pb;
      for (int i = 0; i < spb; i++) q.push_back(pb);
    end
    for (int i = 0; i < stopLen; i++) q.push_back(stopVal);
    if (flipA >= 0) q[flipA] = ~q[flipA];
    if (flipB >= 0) q[flipB] = ~q[flipB];
    foreach (q[i]) oneTick(q[i]);
  endtask

  task automatic expectChar(input string req, input int data, input int fe, input int pe);
    chk(gotData.size() > 0, {req, " character present"}, gotData.size(), 1);
    if (gotData.size() > 0) begin
      int d, f, p;
      d = gotData.pop_front(); f = gotFe.pop_front(); p = gotPe.pop_front();
      chk(d == data, {req, " data"}, d, data);
      chk(f == fe, {req, " frameErr"}, f, fe);
      chk(p == pe, {req, " parityErr"}, p, pe);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rxValid === 1'b0, "R9 reset rxValid", int'(rxValid), 0);
    chk(rxData === 9'd0, "R9 reset rxData", int'(rxData), 0);
    chk(frameErr === 1'b0 && parityErr === 1'b0, "R8 R7 reset flags",
        int'({frameErr, parityErr}), 0);
    rstN = 1'b1;
    idle(4);

    // R2 R6 R12: normal speed, 8 data bits, no parity
    gap = 2; cfgDbl = 0; cfgBits = 8; cfgPar = 0;
    sendFrame(8'hA5, 8, 0, 0, 1, 16, -1, -1); idle(20);
    expectChar("R2 R6 R12 normal 8N", 8'hA5, 0, 0);

    // R7: even parity good and bad
    cfgPar = 1; cfgOdd = 0;
    sendFrame(8'h3C, 8, 1, 0, 1, 16, -1, -1); idle(20);
    expectChar("R7 even good", 8'h3C, 0, 0);
    sendFrame(8'h3D, 8, 1, 1, 1, 16, -1, -1); idle(20);
    expectChar("R7 even bad", 8'h3D, 0, 1);
    cfgOdd = 1;
    sendFrame(8'h81, 8, 2, 0, 1, 16, -1, -1); idle(20);
    expectChar("R7 odd good", 8'h81, 0, 0);
    sendFrame(8'h81, 8, 2, 1, 1, 16, -1, -1); idle(20);
    expectChar("R7 odd bad", 8'h81, 0, 1);
    cfgPar = 0; cfgOdd = 0;

    // R4: one flipped vote sample (middle of data bit 3) ignored
    sendFrame(8'h00, 8, 0, 0, 1, 16, 16 + 3*16 + 8, -1); idle(20);
    expectChar("R4 single flip ignored", 8'h00, 0, 0);
    // R4 R2: two flipped vote samples of data bit 0 (samples 9,10)
    sendFrame(8'h00, 8, 0, 0, 1, 16, 16 + 8, 16 + 9); idle(20);
    expectChar("R4 R2 double flip wins", 8'h01, 0, 0);
    // R2: a flip outside the vote window (sample 12) is ignored
    sendFrame(8'h00, 8, 0, 0, 1, 16, 16 + 11, 16 + 12); idle(20);
    expectChar("R2 off-window flips", 8'h00, 0, 0);

    // R5: start glitch, low for 8 samples only
    for (int i = 0; i < 8; i++) oneTick(1'b0);
    idle(40);
    chk(gotData.size() == 0, "R5 glitch gives no character", gotData.size(), 0);
    sendFrame(8'h5A, 8, 0, 0, 1, 16, -1, -1); idle(20);
    expectChar("R5 after glitch", 8'h5A, 0, 0);

    // R8: stop bit low
    sendFrame(8'hC3, 8, 0, 0, 0, 16, -1, -1); idle(20);
    expectChar("R8 framing error", 8'hC3, 1, 0);

    // R11: line activity without ticks does nothing
    line = 1'b0; repeat (300) @(negedge clk); line = 1'b1; repeat (5) @(negedge clk);
    idle(40);
    chk(gotData.size() == 0, "R11 no tick no frame", gotData.size(), 0);

    // R3: double speed, continuous ticks, 5 bits and 9 bits with odd parity
    gap = 0; cfgDbl = 1; cfgBits = 5;
    sendFrame(5'h15, 5, 0, 0, 1, 8, -1, -1); idle(20);
    expectChar("R3 R6 dbl 5N", 5'h15, 0, 0);
    cfgBits = 9; cfgPar = 1; cfgOdd = 1;
    sendFrame(9'h1A5, 9, 2, 0, 1, 8, -1, -1); idle(20);
    expectChar("R3 R6 dbl 9O", 9'h1A5, 0, 0);
    // R3 R4: flips at samples 5,6 of data bit 2 in double speed
    cfgBits = 8; cfgPar = 0; cfgOdd = 0;
    sendFrame(8'h00, 8, 0, 0, 1, 8, 8 + 2*8 + 4, 8 + 2*8 + 5); idle(20);
    expectChar("R3 R4 dbl vote", 8'h04, 0, 0);

    // R10: stop cut after last vote sample, next start on the following tick
    sendFrame(8'h96, 8, 0, 0, 1, 6, -1, -1);
    sendFrame(8'h69, 8, 0, 0, 1, 8, -1, -1); idle(20);
    expectChar("R10 first of pair dbl", 8'h96, 0, 0);
    expectChar("R10 second of pair dbl", 8'h69, 0, 0);
    cfgDbl = 0; gap = 1;
    sendFrame(8'h11, 8, 0, 0, 1, 10, -1, -1);
    sendFrame(8'hEE, 8, 0, 0, 1, 16, -1, -1); idle(20);
    expectChar("R10 first of pair normal", 8'h11, 0, 0);
    expectChar("R10 second of pair normal", 8'hEE, 0, 0);

    chk(gotData.size() == 0, "R9 no stray characters", gotData.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule